// File: doc/BRIEF.md
# Multi-hart machine timer with per-hart compare

This block keeps one free-running 64-bit time counter shared by a group of harts, plus one 64-bit compare value for each hart. Each hart gets its own timer-interrupt line. The line is high while the counter has reached that hart's compare value. Software moves compare deadlines forward to clear a pending interrupt. It may also load the counter directly, for example after a suspend.

All state is reached over a 32-bit register bus. Every 64-bit quantity is seen as two word halves. Address bit 2 picks the half:
- clear: bits 31:0
- set: bits 63:32

Compare slot k lives at byte offset 8*k, for every offset below 0x7FF8. The counter occupies offsets 0x7FF8 to 0x7FFF. Anything at 0x8000 or above is outside the decoded window and is answered with an error. A separate tick-enable input decides on which clock cycles the counter advances.

Top module: `hart_mtimer`

## Requirements
- R1: While reset is high and right after it, the counter is zero, every compare value is all ones, every interrupt line is low and `rsp_valid` is low.
- R2: The counter adds one on each clock where `tick_en` is high and no counter write happens in that cycle. It holds its value while `tick_en` is low.
- R3: A write to offset 8*k (bit 2 clear) loads bits 31:0 of compare slot k. A write to 8*k+4 loads bits 63:32. The other half keeps its value, and a read of either offset returns that half.
- R4: A write to offset 0x7FF8 loads counter bits 31:0, and a write to 0x7FFC loads bits 63:32. The other half is kept, the tick of that cycle is dropped, and counting resumes from the loaded value. Reads of those offsets return the current halves.
- R5: `irq[h]` is high exactly when counter >= compare[h] as unsigned 64-bit numbers. It shows a change of counter or compare one clock after the register edge that made it.
- R6: A request at offset 0x8000 or above gets `rsp_err` = 1 and `rsp_rdata` = 0. A write there changes no counter or compare state.
- R7: Compare slots with index at or above `NUM_HARTS`, inside the window, read as zero, ignore writes, and respond with `rsp_err` = 0.
- R8: Each cycle with `bus_sel` high produces exactly one response, with `rsp_valid` high on the next cycle. A read response carries the state from before that cycle's edge, and a write response carries zero data.
- R9: The counter wraps from 2^64-1 to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advances on cycles where this is high |
| bus_sel | input | 1 | Request present this cycle |
| bus_we | input | 1 | Request is a write (else a read) |
| bus_addr | input | ADDR_W | Byte offset of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (zero for writes and faults) |
| rsp_err | output | 1 | Access fell outside the decoded window |
| irq | output | NUM_HARTS | Per-hart timer interrupt |

## Verification
The bench builds the block with `NUM_HARTS` = 3 and the default 16-bit offset. This puts slot 3 and slot 4094 inside the window but beyond the populated harts, so the silent zero-read and write-ignore path sits next to real slots. The 16-bit offset also reaches the 0x8000–0xFFFF fault range. Three harts are enough to show that a write to one slot leaves its neighbours alone. The counter is loaded near 2^64 to reach the wrap, and compare values equal to the counter, one above it, and with bit 63 set test the unsigned boundary.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
    localparam int TIME_W   = 64;
    localparam int WORD_W   = 32;
    localparam int IDX_W    = 12;
    localparam logic [31:0] TIME_BASE = 32'h0000_7FF8;
    localparam logic [31:0] WIN_END   = 32'h0000_8000;

    typedef enum logic [1:0] {
        RGN_CMP   = 2'd0,
        RGN_TIME  = 2'd1,
        RGN_FAULT = 2'd2
    } region_e;

    typedef struct packed {
        region_e            region;
        logic               hi;
        logic [IDX_W-1:0]   index;
    } dec_t;

    function automatic logic [TIME_W-1:0] merge_half(
        input logic [TIME_W-1:0] old_v,
        input logic [WORD_W-1:0] word,
        input logic              hi
    );
        merge_half = hi ? {word, old_v[WORD_W-1:0]}
                        : {old_v[TIME_W-1:WORD_W], word};
    endfunction

    function automatic logic [WORD_W-1:0] pick_half(
        input logic [TIME_W-1:0] v,
        input logic              hi
    );
        pick_half = hi ? v[TIME_W-1:WORD_W] : v[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [31:0] off;

    always_comb begin
        off       = 32'(addr);
        dec.hi    = off[2];
        dec.index = off[3 +: IDX_W];
        if (off >= WIN_END)
            dec.region = RGN_FAULT;
        else if (off >= TIME_BASE)
            dec.region = RGN_TIME;
        else
            dec.region = RGN_CMP;
    end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    output logic [TIME_W-1:0] time_o
);
    logic [TIME_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= merge_half(cnt_q, wr_data, wr_hi);
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign time_o = cnt_q;

    // R2: no write and no tick leaves the count alone
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tick) |=> (cnt_q == $past(cnt_q)));

    // R9: the top value rolls over to zero
    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick && (&cnt_q)) |=> (cnt_q == '0));

    // R4: a half write preserves the opposite half
    a_r4_keep_other: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hi) |=> (cnt_q[TIME_W-1:WORD_W] == $past(cnt_q[TIME_W-1:WORD_W])));
endmodule

// File: rtl/mtmr_cmp_bank.sv
module mtmr_cmp_bank
    import mtmr_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic                 rd_hi,
    input  logic [TIME_W-1:0]    time_i,
    output logic [WORD_W-1:0]    rd_data,
    output logic [NUM_HARTS-1:0] irq_o
);
    logic [TIME_W-1:0]    cmp_q [NUM_HARTS];
    logic [NUM_HARTS-1:0] irq_q;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[h] <= '1;
                irq_q[h] <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(h))
                    cmp_q[h] <= merge_half(cmp_q[h], wr_data, wr_hi);
                irq_q[h] <= (time_i >= cmp_q[h]);
            end
        end

        // R5: interrupt follows the unsigned compare one cycle later
        a_r5_irq_tracks: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (irq_q[h] == ($past(time_i) >= $past(cmp_q[h]))));

        // R3: a low-half write keeps the high half
        a_r3_keep_hi: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_hi && wr_idx == IDX_W'(h))
            |=> (cmp_q[h][TIME_W-1:WORD_W] == $past(cmp_q[h][TIME_W-1:WORD_W])));

        // R7: writes to other slots never touch this one
        a_r7_slot_isolated: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_idx == IDX_W'(h))) |=> (cmp_q[h] == $past(cmp_q[h])));
    end

    always_comb begin
        rd_data = '0;
        for (int h = 0; h < NUM_HARTS; h++)
            if (rd_idx == IDX_W'(h))
                rd_data = pick_half(cmp_q[h], rd_hi);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/hart_mtimer.sv
module hart_mtimer
    import mtmr_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic [NUM_HARTS-1:0] irq
);
    dec_t              dec;
    logic [TIME_W-1:0] time_v;
    logic [WORD_W-1:0] cmp_rd;
    logic [WORD_W-1:0] rd_mux;
    logic              time_wr;
    logic              cmp_wr;

    mtmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign time_wr = bus_sel && bus_we && (dec.region == RGN_TIME);
    assign cmp_wr  = bus_sel && bus_we && (dec.region == RGN_CMP);

    mtmr_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .wr_en   (time_wr),
        .wr_hi   (dec.hi),
        .wr_data (bus_wdata),
        .time_o  (time_v)
    );

    mtmr_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmp_wr),
        .wr_hi   (dec.hi),
        .wr_idx  (dec.index),
        .wr_data (bus_wdata),
        .rd_idx  (dec.index),
        .rd_hi   (dec.hi),
        .time_i  (time_v),
        .rd_data (cmp_rd),
        .irq_o   (irq)
    );

    always_comb begin
        case (dec.region)
            RGN_CMP:  rd_mux = cmp_rd;
            RGN_TIME: rd_mux = pick_half(time_v, dec.hi);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_sel;
            rsp_err   <= bus_sel && (dec.region == RGN_FAULT);
            rsp_rdata <= (bus_sel && !bus_we) ? rd_mux : '0;
        end
    end

    // R8: one response per request, next cycle
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !rsp_valid);

    // R6: out-of-window offsets answer with an error and no data
    a_r6_fault_err: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && (32'(bus_addr) >= WIN_END)) |=> (rsp_err && rsp_rdata == '0));

    // R7: every in-window offset answers without error
    a_r7_window_ok: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && (32'(bus_addr) < WIN_END)) |=> !rsp_err);
endmodule

// File: tb/hart_mtimer_tb.sv
module hart_mtimer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NH         = 3;
    localparam int AW         = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [NH-1:0] irq;

    int errors = 0;
    int checks = 0;

    logic [63:0] m_time;
    logic [63:0] m_cmp [NH];

    logic [31:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_mtimer #(.NUM_HARTS(NH), .ADDR_W(AW)) u_dut (
        .clk, .rst, .tick_en, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
        .rsp_valid, .rsp_rdata, .rsp_err, .irq
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        logic [63:0] v;
        int idx;
        if (a >= 16'h8000) return 32'h0;
        if (a >= 16'h7FF8) v = m_time;
        else begin
            idx = int'(a[14:3]);
            if (idx >= NH) return 32'h0;
            v = m_cmp[idx];
        end
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    // driver: one request per cycle, expected response pushed to scoreboard
    task automatic acc(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                       input string tag);
        int idx;
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        q_data.push_back(we ? 32'h0 : model_read(a));
        q_err.push_back(a >= 16'h8000);
        q_tag.push_back(tag);
        if (we && a >= 16'h7FF8 && a < 16'h8000)
            m_time = a[2] ? {d, m_time[31:0]} : {m_time[63:32], d};
        else if (tick_en)
            m_time = m_time + 1;
        if (we && a < 16'h7FF8) begin
            idx = int'(a[14:3]);
            if (idx < NH)
                m_cmp[idx] = a[2] ? {d, m_cmp[idx][31:0]} : {m_cmp[idx][63:32], d};
        end
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            if (tick_en) m_time = m_time + 1;
            @(negedge clk);
        end
    endtask

    // call with tick_en low and state settled for one cycle
    task automatic check_irq(input string req);
        logic [NH-1:0] e;
        for (int h = 0; h < NH; h++) e[h] = (m_time >= m_cmp[h]);
        chk(irq === e, req, 64'(irq), 64'(e));
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R8 unexpected response", 64'(rsp_rdata), 64'h0);
            end else begin
                logic [31:0] ed;
                logic ee;
                string t;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                t  = q_tag.pop_front();
                chk(rsp_rdata === ed && rsp_err === ee, t,
                    {31'h0, rsp_err, rsp_rdata}, {31'h0, ee, ed});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_time = 64'h0;
        for (int h = 0; h < NH; h++) m_cmp[h] = '1;
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(irq === '0, "R1 irq after reset", 64'(irq), 64'h0);
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        acc(0, 16'h7FF8, 0, "R1 time lo reset");
        acc(0, 16'h7FFC, 0, "R1 time hi reset");
        acc(0, 16'h0000, 0, "R1 cmp0 lo reset");
        acc(0, 16'h0014, 0, "R1 cmp2 hi reset");

        // R2: counting and gating
        tick_en = 1'b1;
        idle(10);
        tick_en = 1'b0;
        idle(5);
        acc(0, 16'h7FF8, 0, "R2 count after ticks");
        chk(rsp_valid === 1'b1, "R8 read response valid", 64'(rsp_valid), 64'h1);
        idle(1);
        chk(rsp_valid === 1'b0, "R8 idle no response", 64'(rsp_valid), 64'h0);

        // R3: compare halves
        acc(1, 16'h0008, 32'hAAAA_5555, "R3 write cmp1 lo");
        acc(0, 16'h0008, 0, "R3 read cmp1 lo");
        acc(0, 16'h000C, 0, "R3 cmp1 hi kept");
        acc(1, 16'h000C, 32'h1234_5678, "R3 write cmp1 hi");
        acc(0, 16'h0008, 0, "R3 cmp1 lo kept");
        acc(0, 16'h000C, 0, "R3 read cmp1 hi");
        acc(0, 16'h0000, 0, "R3 cmp0 untouched");

        // R4: time halves, tick dropped in the write cycle
        acc(1, 16'h7FFC, 32'h0000_0001, "R4 write time hi");
        acc(0, 16'h7FF8, 0, "R4 time lo kept");
        acc(0, 16'h7FFC, 0, "R4 time hi loaded");
        tick_en = 1'b1;
        idle(2);
        acc(1, 16'h7FF8, 32'h0000_0010, "R4 write time lo while ticking");
        idle(4);
        tick_en = 1'b0;
        acc(0, 16'h7FF8, 0, "R4 count resumes from loaded value");
        acc(0, 16'h7FFC, 0, "R4 time hi after resume");

        // R5: compare boundary and latency
        acc(1, 16'h7FFC, 32'h0, "R5 time hi 0");
        acc(1, 16'h7FF8, 32'd100, "R5 time lo 100");
        acc(1, 16'h0004, 32'h0, "R5 cmp0 hi 0");
        idle(1);
        check_irq("R5 no irq yet");
        acc(1, 16'h0000, 32'd100, "R5 cmp0 equal");
        chk(irq[0] === 1'b0, "R5 irq one cycle late", 64'(irq[0]), 64'h0);
        idle(1);
        chk(irq[0] === 1'b1, "R5 irq on equal", 64'(irq[0]), 64'h1);
        check_irq("R5 all harts equal case");
        acc(1, 16'h0000, 32'd101, "R5 cmp0 one above");
        idle(1);
        check_irq("R5 cleared one above");
        acc(1, 16'h0010, 32'd5, "R5 cmp2 lo");
        acc(1, 16'h0014, 32'h8000_0000, "R5 cmp2 hi bit63");
        idle(1);
        check_irq("R5 unsigned bit63 compare");
        acc(1, 16'h0014, 32'h0, "R5 cmp2 hi 0");
        idle(1);
        check_irq("R5 cmp2 below time");

        // R6: out-of-window accesses
        acc(0, 16'h8000, 0, "R6 read 0x8000 faults");
        acc(0, 16'hFFFC, 0, "R6 read 0xFFFC faults");
        acc(1, 16'h8004, 32'hDEAD_BEEF, "R6 write fault");
        acc(1, 16'hFFF8, 32'h0, "R6 write fault high");
        idle(1);
        check_irq("R6 irq unchanged after faulted writes");
        acc(0, 16'h7FF8, 0, "R6 time lo unchanged");
        acc(0, 16'h0000, 0, "R6 cmp0 unchanged");

        // R7: unpopulated slots
        acc(1, 16'h0018, 32'h0, "R7 write slot3");
        acc(1, 16'h7FF0, 32'h0, "R7 write slot4094");
        acc(0, 16'h0018, 0, "R7 read slot3 zero");
        acc(0, 16'h7FF4, 0, "R7 read slot4094 hi zero");
        acc(0, 16'h0008, 0, "R7 cmp1 untouched");
        idle(1);
        check_irq("R7 irq unchanged");

        // R9: wrap
        acc(1, 16'h7FFC, 32'hFFFF_FFFF, "R9 time hi max");
        acc(1, 16'h7FF8, 32'hFFFF_FFFE, "R9 time lo max-1");
        tick_en = 1'b1;
        idle(3);
        tick_en = 1'b0;
        acc(0, 16'h7FF8, 0, "R9 lo after wrap");
        acc(0, 16'h7FFC, 0, "R9 hi after wrap");
        idle(1);
        check_irq("R9 irq after wrap");

        idle(2);
        chk(q_data.size() == 0, "R8 all responses seen", 64'(q_data.size()), 64'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule